// File: doc/BRIEF.md
# HDLC Host Register and Interrupt Block

This block is the host-facing slave of an HDLC link controller. A processor reaches it through a memory-style asynchronous bus. The bus has active-low chip select, write enable and output enable strobes, an address bus and a bidirectional data bus. The block synchronises the three strobes to its own clock. A write is committed once it sees the rising edge of write enable while chip select is still low. The block holds the configuration that the transmit and receive logic reads: transmit enable, address-field enable, a two-byte address select and the two address bytes. A write to the control register can also raise a one-cycle end-of-packet or abort command.

Three event pulses come from the datapath: FIFO empty, transmit underrun and transmit done. Each event sets its own sticky bit in a status register. A host read of the status register returns the bits and clears them in the same access. An event that lands on the clear cycle survives it. An active-low service-request line stays low while any status bit has its enable bit set.

Host timing contract: hold output enable low for at least four clocks on a read. Keep chip select low for at least three clocks after write enable rises. Address and write data must stay stable for the whole access.

Top module: `hdlc_host_regs`

## Requirements
- R1: After reset every configuration output, the enable register and the status register are zero, both command pulses are low and irq_n is high.
- R2: A write to offset 0 loads tx_en from data bit 0, hdr_addr_en from bit 1 and hdr_two_byte from bit 2. Writes to offsets 1 and 2 load addr_lo and addr_hi from data bits 7:0. Without a write these outputs hold their values.
- R3: A control write with data bit 3 set gives exactly one one-clock pulse on cmd_eop, and one with bit 4 set gives one on cmd_abort. These bits are not stored and read back as 0.
- R4: Reads return the stored value zero-extended: control in bits 2:0, address bytes in bits 7:0, interrupt enable (offset 3) in bits 2:0. Offsets 5 and up read as zero, and writes to them change nothing.
- R5: Status bit 0 is set by ev_fifo_empty, bit 1 by ev_tx_underrun and bit 2 by ev_tx_done. A set bit stays set until the status register is read or written.
- R6: A read of offset 4 returns the status bits that are set and then clears them.
- R7: An event that is high in the clock cycle where a status read clears the register leaves its bit set after the read.
- R8: irq_n is low exactly when some status bit and the matching enable bit are both set.
- R9: A write to offset 4 loads data bits 2:0 into the status register.
- R10: The block drives data only while cs_n and oe_n are both low. Host writes therefore reach the registers undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | AW | Register offset |
| data | inout | DW | Bidirectional data bus |
| ev_fifo_empty | input | 1 | Transmit FIFO ran empty |
| ev_tx_underrun | input | 1 | Transmitter underrun |
| ev_tx_done | input | 1 | Frame transmission finished |
| tx_en | output | 1 | Transmit enable |
| hdr_addr_en | output | 1 | Send address field |
| hdr_two_byte | output | 1 | Address field is two bytes |
| addr_lo | output | 8 | First address byte |
| addr_hi | output | 8 | Second address byte |
| cmd_eop | output | 1 | End-of-packet command pulse |
| cmd_abort | output | 1 | Abort command pulse |
| irq_n | output | 1 | Service request, active low |

## Verification
On every cycle, the assertions check the following:
- each command pulse lasts a single clock;
- status bits only fall on a status read or write;
- every event lands in its bit;
- a clear keeps the events of its own cycle;
- configuration moves only on a committed write;
- irq_n only falls after an event or a write.

Only the bench scenarios can show the end-to-end bus behaviour. These cover the register map decode, the zero-extended read values and the read-to-clear sequence seen from the host. They also cover the event that races a clear, and the irq_n level against a model of status and enable over random traffic.

// File: rtl/hdlc_host_regs.sv
module hdlc_host_regs #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] data,
  input  logic          ev_fifo_empty,
  input  logic          ev_tx_underrun,
  input  logic          ev_tx_done,
  output logic          tx_en,
  output logic          hdr_addr_en,
  output logic          hdr_two_byte,
  output logic [7:0]    addr_lo,
  output logic [7:0]    addr_hi,
  output logic          cmd_eop,
  output logic          cmd_abort,
  output logic          irq_n
);
  localparam int NEV = 3;
  localparam logic [AW-1:0] OFS_CTRL = AW'(0);
  localparam logic [AW-1:0] OFS_AD1  = AW'(1);
  localparam logic [AW-1:0] OFS_AD2  = AW'(2);
  localparam logic [AW-1:0] OFS_IEN  = AW'(3);
  localparam logic [AW-1:0] OFS_STAT = AW'(4);

  // strobe synchronisers: {cs, we, oe}
  logic [2:0] sy1, sy2, sy3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1; sy2 <= '1; sy3 <= '1;
    end else begin
      sy1 <= {cs_n, we_n, oe_n};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  wire sel       = ~sy2[2];
  wire wr_commit = sel & sy2[1] & ~sy3[1];
  wire rd_now    = sel & ~sy2[0];
  wire rd_prev   = ~sy3[2] & ~sy3[0];
  wire rd_start  = rd_now & ~rd_prev & (addr == OFS_STAT);
  wire wr_stat   = wr_commit & (addr == OFS_STAT);

  wire [DW-1:0]  wd = data;
  wire [NEV-1:0] ev = {ev_tx_done, ev_tx_underrun, ev_fifo_empty};
  wire unused_hi = ^wd[DW-1:8];

  logic [NEV-1:0] ien, status, snap;
  logic           snap_vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_en <= 1'b0; hdr_addr_en <= 1'b0; hdr_two_byte <= 1'b0;
      addr_lo <= '0; addr_hi <= '0; ien <= '0;
      cmd_eop <= 1'b0; cmd_abort <= 1'b0;
    end else begin
      cmd_eop   <= 1'b0;
      cmd_abort <= 1'b0;
      if (wr_commit)
        case (addr)
          OFS_CTRL: begin
            tx_en        <= wd[0];
            hdr_addr_en  <= wd[1];
            hdr_two_byte <= wd[2];
            cmd_eop      <= wd[3];
            cmd_abort    <= wd[4];
          end
          OFS_AD1: addr_lo <= wd[7:0];
          OFS_AD2: addr_hi <= wd[7:0];
          OFS_IEN: ien     <= wd[NEV-1:0];
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status <= '0; snap <= '0; snap_vld <= 1'b0;
    end else begin
      if (!rd_now) snap_vld <= 1'b0;
      if (rd_start) begin
        snap     <= status | ev;
        snap_vld <= 1'b1;
        status   <= ev;
      end else if (wr_stat) begin
        status <= wd[NEV-1:0] | ev;
      end else begin
        status <= status | ev;
      end
    end

  logic [DW-1:0] rdata;
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: rdata[2:0]     = {hdr_two_byte, hdr_addr_en, tx_en};
      OFS_AD1:  rdata[7:0]     = addr_lo;
      OFS_AD2:  rdata[7:0]     = addr_hi;
      OFS_IEN:  rdata[NEV-1:0] = ien;
      OFS_STAT: rdata[NEV-1:0] = snap_vld ? snap : status;
      default:  ;
    endcase
  end

  assign data  = (!cs_n && !oe_n) ? rdata : {DW{1'bz}};
  assign irq_n = ~|(status & ien);

  assert_eop_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_eop |=> !cmd_eop);
  assert_abort_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_start && !wr_stat) |=> ((status & $past(status)) == $past(status)));
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((status & $past(ev)) == $past(ev)));
  assert_clear_keeps_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (status == $past(ev)));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable({tx_en, hdr_addr_en, hdr_two_byte, addr_lo, addr_hi}));
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past((|ev) || wr_commit));
endmodule

// File: tb/tb_hdlc_host_regs.sv
module tb_hdlc_host_regs;
  localparam int DW = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] drv_val = '0;
  logic drv_en = 1'b0;
  wire  [DW-1:0] data;
  logic e_empty = 1'b0, e_urun = 1'b0, e_done = 1'b0;
  logic tx_en, hdr_addr_en, hdr_two_byte, cmd_eop, cmd_abort, irq_n;
  logic [7:0] addr_lo, addr_hi;

  assign data = drv_en ? drv_val : {DW{1'bz}};

  hdlc_host_regs #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .ev_fifo_empty(e_empty),
    .ev_tx_underrun(e_urun), .ev_tx_done(e_done), .tx_en(tx_en),
    .hdr_addr_en(hdr_addr_en), .hdr_two_byte(hdr_two_byte),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .cmd_eop(cmd_eop),
    .cmd_abort(cmd_abort), .irq_n(irq_n));

  int n_run = 0, n_fail = 0;
  int eop_seen = 0, abort_seen = 0, eop_exp = 0, abort_exp = 0;
  bit done = 0;

  logic [2:0] m_ctrl = '0, m_ien = '0, m_stat = '0;
  logic [7:0] m_lo = '0, m_hi = '0;

  always @(negedge clk) begin
    if (cmd_eop) eop_seen++;
    if (cmd_abort) abort_seen++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {13'd0, m_ctrl};
      4'd1: return {8'd0, m_lo};
      4'd2: return {8'd0, m_hi};
      4'd3: return {13'd0, m_ien};
      4'd4: return {13'd0, m_stat};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ~|(m_stat & m_ien);
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; drv_val = d; drv_en = 1'b1;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
    case (a)
      4'd0: begin
        m_ctrl = d[2:0];
        if (d[3]) eop_exp++;
        if (d[4]) abort_exp++;
      end
      4'd1: m_lo = d[7:0];
      4'd2: m_hi = d[7:0];
      4'd3: m_ien = d[2:0];
      4'd4: m_stat = d[2:0];
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    d = data;
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ev(input logic [2:0] e);
    @(negedge clk); {e_done, e_urun, e_empty} = e;
    @(negedge clk); {e_done, e_urun, e_empty} = 3'b000;
    m_stat = m_stat | e;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    chk("R1 outputs after reset",
        {20'd0, tx_en, hdr_addr_en, hdr_two_byte, addr_lo, addr_hi, cmd_eop, cmd_abort},
        32'd0);
    chk("R1 irq_n after reset", irq_n, 1'b1);
    bus_read(4'd4, rv);
    chk("R1 status after reset", rv, 16'd0);

    bus_write(4'd0, 16'hFFFF);
    chk("R2 ctrl outputs", {tx_en, hdr_addr_en, hdr_two_byte}, 3'b111);
    chk("R3 eop pulse count", eop_seen, eop_exp);
    chk("R3 abort pulse count", abort_seen, abort_exp);
    bus_read(4'd0, rv);
    chk("R3 command bits read zero", rv, 16'h0007);
    bus_write(4'd1, 16'hA55A);
    chk("R2 addr_lo", addr_lo, 8'h5A);
    bus_write(4'd2, 16'h3CC3);
    chk("R2 addr_hi", addr_hi, 8'hC3);
    chk("R10 write unaffected by bus driver", {addr_lo, addr_hi}, 16'h5AC3);

    bus_write(4'd9, 16'hFFFF);
    bus_read(4'd9, rv);
    chk("R4 unmapped reads zero", rv, 16'd0);
    chk("R4 unmapped write no effect", {addr_lo, addr_hi, tx_en, hdr_addr_en, hdr_two_byte},
        {8'h5A, 8'hC3, 3'b111});

    bus_write(4'd3, 16'h0007);
    pulse_ev(3'b001);
    chk("R8 irq after empty event", irq_n, 1'b0);
    @(negedge clk); cs_n = 1'b0; addr = 4'd4; oe_n = 1'b0;
    @(negedge clk); e_done = 1'b1;
    @(negedge clk);
    @(negedge clk); e_done = 1'b0;
    repeat (2) @(negedge clk);
    rv = data;
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 status read value", rv, 16'h0005);
    m_stat = 3'b100;
    bus_read(4'd4, rv);
    chk("R7 event on clear cycle kept", rv, 16'h0004);
    m_stat = 3'b000;
    bus_read(4'd4, rv);
    chk("R6 status cleared by read", rv, 16'h0000);
    chk("R8 irq released", irq_n, 1'b1);

    bus_write(4'd4, 16'h0002);
    bus_read(4'd4, rv);
    chk("R9 status write loads", rv, 16'h0002);
    m_stat = 3'b000;

    for (int i = 0; i < 250; i++) begin
      int op;
      logic [3:0] a;
      logic [15:0] d, e;
      op = $urandom_range(0, 2);
      a  = 4'($urandom_range(0, 7));
      d  = 16'($urandom);
      if (op == 0) begin
        bus_write(a, d);
        chk("R2 R4 R9 config after random write",
            {tx_en, hdr_addr_en, hdr_two_byte, addr_lo, addr_hi},
            {m_ctrl[0], m_ctrl[1], m_ctrl[2], m_lo, m_hi});
      end else if (op == 1) begin
        e = exp_read(a);
        bus_read(a, rv);
        chk("R4 R6 random read", rv, e);
        if (a == 4'd4) m_stat = 3'b000;
      end else begin
        pulse_ev(3'($urandom_range(1, 7)));
      end
      chk("R8 irq level", irq_n, exp_irq());
    end
    chk("R3 eop total pulses", eop_seen, eop_exp);
    chk("R3 abort total pulses", abort_seen, abort_exp);
    bus_read(4'd4, rv);
    chk("R5 R6 final status", rv, {13'd0, m_stat});

    finish_run();
  end
endmodule